// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block lives inside a DDR SDRAM controller and performs the mode-register set-up of the memory once the controller asks for it. A single-cycle start pulse hands it the wanted burst length code, burst ordering, CAS latency code, DLL enable and a reduced output-drive option. The block checks the codes, captures them, and then drives the command lines (chip select, row strobe, column strobe, write enable), the bank-select lines and the row address bus with a short series of load-mode commands. NOP cycles separate the commands.

With the DLL enabled, the series is: a write to the extended register, then a base-register write with the DLL-reset bit set, then a base-register write for normal operation. With the DLL disabled, the middle write is skipped. A command is only placed on the bus while the controller reports every bank idle and no burst running. A programmable number of NOP cycles follows each command. A reserved burst-length or latency code is refused with an error flag, and no command is issued.

Top module: `ddr_mrs_seq`

## Requirements
- R1: While reset is asserted, cs_n, ras_n, cas_n and we_n are all high, and busy, done and err are all low.
- R2: A load-mode command is cs_n, ras_n, cas_n and we_n all low, and it lasts exactly one cycle. Every other cycle after reset drives NOP: cs_n low, with ras_n, cas_n and we_n high.
- R3: With dll_enable=1 the order is extended register (ba=01), base register with addr[8]=1, then base register with addr[12:7] all zero. With dll_enable=0 it is extended register, then the normal base-register write only. The extended word carries addr[0] = not dll_enable and addr[1] = drive_reduced, with all other bits zero.
- R4: Every base-register word (ba=00) carries addr[2:0] = burst length code, addr[3] = burst_interleave (0 sequential, 1 interleaved), addr[6:4] = latency code, and zero in addr[12:9] and addr[7].
- R5: Only burst length codes 001, 010 and 011 are accepted, and only latency codes 010 and 110. Any other code at start sets err and issues no command, and busy stays low.
- R6: A load-mode command is issued only when banks_idle was 1 and burst_active was 0 in the previous cycle. Otherwise the sequencer holds with NOP until the bus is free.
- R7: At least GAP_CYCLES NOP cycles follow each load-mode command. When the bus stays free, there are exactly GAP_CYCLES.
- R8: done rises GAP_CYCLES cycles after the cycle carrying the final command, and busy falls in the same cycle.
- R9: A start pulse while busy is ignored. The running sequence keeps its captured settings and its command count.
- R10: An accepted start clears done and err. A start with legal codes clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the programming sequence |
| bl_code | input | 3 | Burst length code |
| burst_interleave | input | 1 | Burst ordering, 1 = interleaved |
| cl_code | input | 3 | CAS latency code |
| dll_enable | input | 1 | Enable the DLL and run the DLL-reset write |
| drive_reduced | input | 1 | Select reduced output drive |
| banks_idle | input | 1 | All banks are precharged and idle |
| burst_active | input | 1 | A read or write burst is in progress |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank select (00 base, 01 extended register) |
| addr | output | ROW_W | Address bus carrying the register word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until the next accepted start |
| err | output | 1 | Reserved code refused, held until the next accepted start |

## Verification
A wrong sequencer state shows up on the command pins within one command slot. It can appear as a missing or extra load-mode write, a base write where the extended one belongs, or a DLL-reset word left out. A corrupted spacing counter shifts the next command by whole cycles, so the NOP run between commands differs from GAP_CYCLES. A faulty capture or field packing changes the address word on the very cycle the command appears. A broken bus-free check lets a command through while banks_idle is low, in the cycle after the stall begins.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EXT,
      ST_EXT_GAP,
      ST_DRST,
      ST_DRST_GAP,
      ST_NORM,
      ST_NORM_GAP
   } seq_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } ddr_cmd_t;

   localparam ddr_cmd_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
   localparam ddr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam ddr_cmd_t CMD_DES = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

   localparam int unsigned MODE_WORD_W = 13;
   localparam int unsigned DLL_RST_BIT = 8;

   function automatic logic burst_code_legal(input logic [2:0] code);
      return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
   endfunction

   function automatic logic latency_code_legal(input logic [2:0] code);
      return (code == 3'b010) || (code == 3'b110);
   endfunction

endpackage

// File: rtl/ddr_mrs_word_build.sv
module ddr_mrs_word_build
   import ddr_mrs_pkg::*;
#(
   parameter int unsigned ROW_W = 13
) (
   input  logic [2:0]       bl_code,
   input  logic             burst_interleave,
   input  logic [2:0]       cl_code,
   input  logic             dll_enable,
   input  logic             drive_reduced,
   output logic             cfg_ok,
   output logic [ROW_W-1:0] word_ext,
   output logic [ROW_W-1:0] word_drst,
   output logic [ROW_W-1:0] word_norm
);

   logic [MODE_WORD_W-1:0] base13;
   logic [MODE_WORD_W-1:0] drst13;
   logic [MODE_WORD_W-1:0] ext13;

   always_comb begin
      base13 = '0;
      base13[2:0] = bl_code;
      base13[3]   = burst_interleave;
      base13[6:4] = cl_code;
      drst13 = base13;
      drst13[DLL_RST_BIT] = 1'b1;
      ext13 = '0;
      ext13[0] = ~dll_enable;
      ext13[1] = drive_reduced;
   end

   assign cfg_ok = burst_code_legal(bl_code) && latency_code_legal(cl_code);

   generate
      if (ROW_W == MODE_WORD_W) begin : g_exact
         assign word_ext  = ext13;
         assign word_drst = drst13;
         assign word_norm = base13;
      end else begin : g_wide
         localparam int unsigned PAD_W = ROW_W - MODE_WORD_W;
         assign word_ext  = {{PAD_W{1'b0}}, ext13};
         assign word_drst = {{PAD_W{1'b0}}, drst13};
         assign word_norm = {{PAD_W{1'b0}}, base13};
      end
   endgenerate

endmodule

// File: rtl/ddr_mrs_gap_timer.sv
module ddr_mrs_gap_timer #(
   parameter int unsigned GAP_CYCLES = 2,
   localparam int unsigned CNT_W = $clog2(GAP_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= CNT_W'(GAP_CYCLES);
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = run && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ddr_mrs_ctrl.sv
module ddr_mrs_ctrl
   import ddr_mrs_pkg::*;
#(
   parameter int unsigned ROW_W  = 13,
   parameter int unsigned BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_ok,
   input  logic              dll_enable,
   input  logic [ROW_W-1:0]  word_ext,
   input  logic [ROW_W-1:0]  word_drst,
   input  logic [ROW_W-1:0]  word_norm,
   input  logic              banks_idle,
   input  logic              burst_active,
   input  logic              gap_last,
   output logic              gap_load,
   output logic              gap_run,
   output ddr_cmd_t          cmd,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr,
   output logic              busy,
   output logic              done,
   output logic              err
);

   localparam logic [BANK_W-1:0] BANK_BASE = BANK_W'(0);
   localparam logic [BANK_W-1:0] BANK_EXT  = BANK_W'(1);

   seq_state_t       state_q;
   logic             dll_q;
   logic [ROW_W-1:0] ext_q;
   logic [ROW_W-1:0] drst_q;
   logic [ROW_W-1:0] norm_q;
   logic             bus_free;
   logic             issuing;

   assign bus_free = banks_idle && !burst_active;
   assign issuing  = bus_free &&
                     ((state_q == ST_EXT) || (state_q == ST_DRST) || (state_q == ST_NORM));
   assign gap_load = issuing;
   assign gap_run  = (state_q == ST_EXT_GAP) || (state_q == ST_DRST_GAP) ||
                     (state_q == ST_NORM_GAP);
   assign busy     = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd     <= CMD_DES;
         ba      <= '0;
         addr    <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
         dll_q   <= 1'b0;
         ext_q   <= '0;
         drst_q  <= '0;
         norm_q  <= '0;
      end else begin
         cmd  <= CMD_NOP;
         ba   <= '0;
         addr <= '0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  done <= 1'b0;
                  if (cfg_ok) begin
                     err     <= 1'b0;
                     dll_q   <= dll_enable;
                     ext_q   <= word_ext;
                     drst_q  <= word_drst;
                     norm_q  <= word_norm;
                     state_q <= ST_EXT;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            ST_EXT: begin
               if (bus_free) begin
                  cmd     <= CMD_LMR;
                  ba      <= BANK_EXT;
                  addr    <= ext_q;
                  state_q <= ST_EXT_GAP;
               end
            end
            ST_EXT_GAP: begin
               if (gap_last) state_q <= dll_q ? ST_DRST : ST_NORM;
            end
            ST_DRST: begin
               if (bus_free) begin
                  cmd     <= CMD_LMR;
                  ba      <= BANK_BASE;
                  addr    <= drst_q;
                  state_q <= ST_DRST_GAP;
               end
            end
            ST_DRST_GAP: begin
               if (gap_last) state_q <= ST_NORM;
            end
            ST_NORM: begin
               if (bus_free) begin
                  cmd     <= CMD_LMR;
                  ba      <= BANK_BASE;
                  addr    <= norm_q;
                  state_q <= ST_NORM_GAP;
               end
            end
            ST_NORM_GAP: begin
               if (gap_last) begin
                  state_q <= ST_IDLE;
                  done    <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
   import ddr_mrs_pkg::*;
#(
   parameter int unsigned ROW_W      = 13,
   parameter int unsigned BANK_W     = 2,
   parameter int unsigned GAP_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        bl_code,
   input  logic              burst_interleave,
   input  logic [2:0]        cl_code,
   input  logic              dll_enable,
   input  logic              drive_reduced,
   input  logic              banks_idle,
   input  logic              burst_active,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr,
   output logic              busy,
   output logic              done,
   output logic              err
);

   generate
      if (ROW_W < MODE_WORD_W) begin : g_bad_row
         $error("ROW_W must cover the 13-bit mode word");
      end
      if (BANK_W < 2) begin : g_bad_bank
         $error("BANK_W must be at least 2");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 1");
      end
   endgenerate

   logic             cfg_ok;
   logic [ROW_W-1:0] word_ext;
   logic [ROW_W-1:0] word_drst;
   logic [ROW_W-1:0] word_norm;
   logic             gap_load;
   logic             gap_run;
   logic             gap_last;
   ddr_cmd_t         cmd;

   ddr_mrs_word_build #(.ROW_W(ROW_W)) i_build (
      .bl_code          (bl_code),
      .burst_interleave (burst_interleave),
      .cl_code          (cl_code),
      .dll_enable       (dll_enable),
      .drive_reduced    (drive_reduced),
      .cfg_ok           (cfg_ok),
      .word_ext         (word_ext),
      .word_drst        (word_drst),
      .word_norm        (word_norm)
   );

   ddr_mrs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (gap_load),
      .run   (gap_run),
      .last  (gap_last)
   );

   ddr_mrs_ctrl #(.ROW_W(ROW_W), .BANK_W(BANK_W)) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cfg_ok       (cfg_ok),
      .dll_enable   (dll_enable),
      .word_ext     (word_ext),
      .word_drst    (word_drst),
      .word_norm    (word_norm),
      .banks_idle   (banks_idle),
      .burst_active (burst_active),
      .gap_last     (gap_last),
      .gap_load     (gap_load),
      .gap_run      (gap_run),
      .cmd          (cmd),
      .ba           (ba),
      .addr         (addr),
      .busy         (busy),
      .done         (done),
      .err          (err)
   );

   assign cs_n  = cmd.cs_n;
   assign ras_n = cmd.ras_n;
   assign cas_n = cmd.cas_n;
   assign we_n  = cmd.we_n;

endmodule

// File: rtl/ddr_mrs_seq_chk.sv
module ddr_mrs_seq_chk #(
   parameter int unsigned ROW_W      = 13,
   parameter int unsigned BANK_W     = 2,
   parameter int unsigned GAP_CYCLES = 2,
   localparam int unsigned SINCE_W   = $clog2(GAP_CYCLES + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              banks_idle,
   input logic              burst_active,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] ba,
   input logic [ROW_W-1:0]  addr,
   input logic              busy,
   input logic              done,
   input logic              err
);

   logic               lmr;
   logic [SINCE_W-1:0] since_q;

   assign lmr = !cs_n && !ras_n && !cas_n && !we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= SINCE_W'(GAP_CYCLES);
      end else if (lmr) begin
         since_q <= '0;
      end else if (since_q < SINCE_W'(GAP_CYCLES)) begin
         since_q <= since_q + 1'b1;
      end
   end

   a_r2_cmd_shape: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> ((ras_n == cas_n) && (cas_n == we_n)));

   a_r3_bank_legal: assert property (@(posedge clk) disable iff (!rst_n)
      lmr |-> (ba == BANK_W'(0)) || (ba == BANK_W'(1)));

   a_r3_ext_word: assert property (@(posedge clk) disable iff (!rst_n)
      (lmr && ba == BANK_W'(1)) |-> (addr[ROW_W-1:2] == '0));

   a_r4_opmode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (lmr && ba == BANK_W'(0)) |-> (addr[ROW_W-1:9] == '0) && !addr[7]);

   a_r5_codes_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (lmr && ba == BANK_W'(0)) |->
         (addr[2:0] inside {3'b001, 3'b010, 3'b011}) && (addr[6:4] inside {3'b010, 3'b110}));

   a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);

   a_r6_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
      lmr |-> $past(banks_idle && !burst_active));

   a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      lmr |-> (since_q >= SINCE_W'(GAP_CYCLES)));

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !err);

   logic unused_addr;
   assign unused_addr = addr[8] ^ addr[3] ^ addr[1] ^ addr[0];

endmodule

bind ddr_mrs_seq ddr_mrs_seq_chk #(
   .ROW_W(ROW_W), .BANK_W(BANK_W), .GAP_CYCLES(GAP_CYCLES)
) i_chk (
   .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .burst_active(burst_active),
   .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
   .busy(busy), .done(done), .err(err)
);

// File: tb/test_ddr_mrs_seq.sv
module test_ddr_mrs_seq;

   localparam int ROW_W = 13;
   localparam int BANK_W = 2;
   localparam int GAP = 3;

   typedef struct packed {
      logic [2:0] bl;
      logic       bt;
      logic [2:0] cl;
      logic       dll;
      logic       drv;
      logic       exp_err;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{bl: 3'b001, bt: 1'b0, cl: 3'b010, dll: 1'b1, drv: 1'b0, exp_err: 1'b0},
      '{bl: 3'b010, bt: 1'b1, cl: 3'b110, dll: 1'b1, drv: 1'b1, exp_err: 1'b0},
      '{bl: 3'b011, bt: 1'b0, cl: 3'b110, dll: 1'b0, drv: 1'b0, exp_err: 1'b0},
      '{bl: 3'b100, bt: 1'b0, cl: 3'b010, dll: 1'b1, drv: 1'b0, exp_err: 1'b1},
      '{bl: 3'b011, bt: 1'b1, cl: 3'b010, dll: 1'b0, drv: 1'b1, exp_err: 1'b0},
      '{bl: 3'b010, bt: 1'b0, cl: 3'b011, dll: 1'b1, drv: 1'b0, exp_err: 1'b1},
      '{bl: 3'b000, bt: 1'b1, cl: 3'b101, dll: 1'b0, drv: 1'b0, exp_err: 1'b1},
      '{bl: 3'b001, bt: 1'b1, cl: 3'b110, dll: 1'b1, drv: 1'b1, exp_err: 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] bl_code = 3'b001;
   logic burst_interleave = 1'b0;
   logic [2:0] cl_code = 3'b010;
   logic dll_enable = 1'b1;
   logic drive_reduced = 1'b0;
   logic banks_idle = 1'b1;
   logic burst_active = 1'b0;
   logic cs_n, ras_n, cas_n, we_n;
   logic [BANK_W-1:0] ba;
   logic [ROW_W-1:0] addr;
   logic busy, done, err;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   int n_lmr;
   int done_cyc;
   logic [BANK_W-1:0] lmr_ba [4];
   logic [ROW_W-1:0] lmr_addr [4];
   int lmr_cyc [4];

   always #10 clk = ~clk;

   ddr_mrs_seq #(.ROW_W(ROW_W), .BANK_W(BANK_W), .GAP_CYCLES(GAP)) i_ddr_mrs_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .bl_code(bl_code),
      .burst_interleave(burst_interleave), .cl_code(cl_code), .dll_enable(dll_enable),
      .drive_reduced(drive_reduced), .banks_idle(banks_idle), .burst_active(burst_active),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .busy(busy), .done(done), .err(err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic is_lmr();
      return !cs_n && !ras_n && !cas_n && !we_n;
   endfunction

   task automatic apply(input vec_t v);
      bl_code = v.bl; burst_interleave = v.bt; cl_code = v.cl;
      dll_enable = v.dll; drive_reduced = v.drv;
   endtask

   task automatic pulse_start(input vec_t v);
      apply(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic collect();
      n_lmr = 0;
      done_cyc = -1;
      for (int k = 1; k < 200; k++) begin
         @(negedge clk);
         if (is_lmr() && n_lmr < 4) begin
            lmr_ba[n_lmr] = ba; lmr_addr[n_lmr] = addr; lmr_cyc[n_lmr] = k;
            n_lmr++;
         end
         if (done || err) begin
            done_cyc = k;
            break;
         end
      end
   endtask

   function automatic logic [ROW_W-1:0] exp_norm(input vec_t v);
      logic [ROW_W-1:0] w = '0;
      w[2:0] = v.bl; w[3] = v.bt; w[6:4] = v.cl;
      return w;
   endfunction

   task automatic check_seq(input vec_t v, input bit exact_gap);
      int en;
      if (v.exp_err) begin
         check(err == 1'b1, "R5", "err on reserved code", 32'(err), 1);
         check(n_lmr == 0, "R5", "no command on reserved code", n_lmr, 0);
         check(busy == 1'b0, "R5", "busy on reserved code", 32'(busy), 0);
         return;
      end
      en = v.dll ? 3 : 2;
      check(n_lmr == en, "R3", "command count", n_lmr, en);
      check(err == 1'b0 && done == 1'b1, "R10", "err clear, done set", {err, done}, 2'b01);
      if (n_lmr != en) return;
      check(lmr_ba[0] == 2'b01, "R3", "first bank", lmr_ba[0], 2'b01);
      check(lmr_addr[0] == ROW_W'({v.drv, ~v.dll}), "R3", "extended word",
            lmr_addr[0], {v.drv, ~v.dll});
      if (v.dll) begin
         check(lmr_ba[1] == 2'b00, "R3", "dll reset bank", lmr_ba[1], 0);
         check(lmr_addr[1] == (exp_norm(v) | 13'h100), "R3", "dll reset word",
               lmr_addr[1], exp_norm(v) | 13'h100);
      end
      check(lmr_ba[en-1] == 2'b00, "R4", "normal bank", lmr_ba[en-1], 0);
      check(lmr_addr[en-1] == exp_norm(v), "R4", "normal word", lmr_addr[en-1], exp_norm(v));
      if (exact_gap) begin
         for (int i = 1; i < en; i++)
            check(lmr_cyc[i] - lmr_cyc[i-1] - 1 == GAP, "R7", "nop gap",
                  lmr_cyc[i] - lmr_cyc[i-1] - 1, GAP);
      end
      check(done_cyc - lmr_cyc[en-1] == GAP, "R8", "done delay",
            done_cyc - lmr_cyc[en-1], GAP);
      check(busy == 1'b0, "R8", "busy low with done", 32'(busy), 0);
   endtask

   task automatic stall_test(input bit use_burst);
      vec_t v = VECS[0];
      if (use_burst) burst_active = 1'b1; else banks_idle = 1'b0;
      pulse_start(v);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check(!is_lmr() && !cs_n && busy, "R6", "hold NOP while bus not free",
               {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      end
      banks_idle = 1'b1;
      burst_active = 1'b0;
      collect();
      check_seq(v, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "reset command lines",
            {cs_n, ras_n, cas_n, we_n}, 4'b1111);
      check({busy, done, err} == 3'b000, "R1", "reset flags", {busy, done, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2", "idle NOP",
            {cs_n, ras_n, cas_n, we_n}, 4'b0111);

      for (int i = 0; i < NV; i++) begin
         pulse_start(VECS[i]);
         collect();
         check_seq(VECS[i], 1'b1);
         repeat (2) @(negedge clk);
      end

      // R6: stall before the first command, once per stall source
      stall_test(1'b0);
      stall_test(1'b1);

      // R9: start while busy is ignored, captured settings kept
      pulse_start(VECS[0]);
      @(negedge clk);
      pulse_start(VECS[4]);
      collect();
      check(n_lmr == 2, "R9", "remaining commands", n_lmr, 2);
      check(lmr_addr[n_lmr-1] == exp_norm(VECS[0]), "R9", "captured word kept",
            lmr_addr[n_lmr-1], exp_norm(VECS[0]));

      // R2: one-cycle command width
      pulse_start(VECS[2]);
      @(negedge clk);
      check(is_lmr(), "R2", "command present", {cs_n, ras_n, cas_n, we_n}, 0);
      @(negedge clk);
      check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2", "command one cycle",
            {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      collect();

      // R10: error then a good start clears it
      pulse_start(VECS[3]);
      check(err == 1'b1, "R10", "err set", 32'(err), 1);
      pulse_start(VECS[1]);
      check(err == 1'b0 && done == 1'b0, "R10", "start clears flags", {err, done}, 0);
      collect();

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule